// File: doc/BRIEF.md
# Configuration Word Aligner

This block sits between a byte-wide source of configuration data and a port that takes 32-bit words. It packs bytes into words with the earliest byte in the most significant lane. Before the synchronisation keyword `0xAA995566` it does not pack blindly. It watches the byte stream through a three-byte lookahead window. When the keyword appears at any byte offset, the block finishes the partly filled word with `0xFF` fill bytes, so the keyword leaves as one whole output word. The fill lands in the dummy region between the bus-width detection pair (`0x000000BB` followed by `0x11220044`) and the keyword. The detection pair keeps its byte order, and nothing is inserted inside it.

Once the keyword has gone out, the block raises its `locked` flag and packs every following byte straight through, without searching. An output word equal to the end keyword `0x0000000D` is emitted normally. In the same cycle the block pulses `stream_end`, drops `locked`, and goes back to searching for the next keyword.

Both data interfaces follow valid/ready rules. A transfer happens on a rising clock edge where valid and ready are both high. The source must hold `byte_valid` and `byte_data` stable until it sees `byte_ready`. `byte_ready` may depend on `byte_valid`, because it drops while a fill word is waiting to be emitted. The block holds `word_valid` and `word_data` steady while `word_ready` is low. Back-pressure only stalls the input when the byte in hand would complete a word and the output register is still occupied.

Top module: `cfg_word_aligner`

## Requirements
- R1: While and just after the reset input (`rst_n`, active low) is asserted, `word_valid`, `locked` and `stream_end` are low and `byte_ready` is high.
- R2: Output words carry the input bytes in their arrival order, with the earliest byte in bits 31:24 and the latest in bits 7:0.
- R3: If the keyword starts when 1, 2 or 3 bytes of a word are already collected, the block first emits that word with its empty low lanes filled with `0xFF`, and then emits `0xAA995566` as the next word.
- R4: If the keyword starts on a word boundary, including as the very first bytes after reset or after an end, no fill word is emitted.
- R5: `locked` rises in the first cycle the keyword word is presented on `word_data`. It stays high for every word that follows, up to but not including the end word.
- R6: While locked, the byte sequence `AA 99 55 66` is packed as ordinary data at any offset and causes no fill.
- R7: When a locked output word equals `0x0000000D`, `stream_end` is high for exactly one cycle, the first cycle that word is presented. `locked` is low in that same cycle, and the next keyword is searched for again.
- R8: While `word_valid` is high and `word_ready` is low, `word_data` and `word_valid` stay unchanged.
- R9: Idle gaps on `byte_valid` and random back-pressure on `word_ready` neither lose, duplicate nor reorder any byte.
- R10: A partial keyword prefix in the preamble (for example `AA 99 55` followed by another byte) passes through unchanged and triggers no fill.
- R11: Width detection bytes `00 00 00 BB 11 22 00 44` that come before the keyword reach the output in the same order and with no byte inserted among them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid | input | 1 | Input byte is offered |
| byte_ready | output | 1 | Block accepts the offered byte this cycle |
| byte_data | input | 8 | Input byte |
| word_valid | output | 1 | Output word is presented |
| word_ready | input | 1 | Sink accepts the output word |
| word_data | output | 32 | Output word, first byte in bits 31:24 |
| locked | output | 1 | Keyword seen and emitted, packing without search |
| stream_end | output | 1 | One-cycle pulse with the end keyword word |

## Verification
The bench builds the block with its default keyword, end word and fill byte, and with four byte lanes. These values let it reach every possible keyword offset: 0 to 3 collected bytes, each on a stream of its own. It also covers preambles that hold the width detection pair and partial keyword prefixes, and a keyword copy in the payload at a word boundary and across two words. A final run turns on random input gaps and random output back-pressure, so that fill words and keyword loads collide with a busy output register.

// File: rtl/cfg_align_pkg.sv
package cfg_align_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = BYTE_W * LANES;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {MODE_SEEK, MODE_LOCKED} mode_t;

  localparam word_t SYNC_DEFAULT  = 32'hAA99_5566;
  localparam word_t END_DEFAULT   = 32'h0000_000D;
  localparam byte_t FILL_DEFAULT  = 8'hFF;
endpackage

// File: rtl/cfg_align_window.sv
module cfg_align_window
  import cfg_align_pkg::*;
#(
  parameter word_t KEY = SYNC_DEFAULT
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift,
  input  logic  clear,
  input  byte_t din,
  output logic  full,
  output logic  match,
  output byte_t oldest
);
  localparam int HOLD = LANES - 1;
  localparam int CW   = $clog2(LANES);

  byte_t            hold [HOLD];
  logic [CW-1:0]    cnt;
  logic [LANES-1:0] lane_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < HOLD; i++) hold[i] <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift) begin
      for (int i = 0; i < HOLD - 1; i++) hold[i] <= hold[i+1];
      hold[HOLD-1] <= din;
      if (!full) cnt <= cnt + 1'b1;
    end
  end

  assign full   = (cnt == CW'(HOLD));
  assign oldest = hold[0];

  for (genvar k = 0; k < HOLD; k++) begin : g_lane
    assign lane_eq[k] = (hold[k] == KEY[WORD_W-1-BYTE_W*k -: BYTE_W]);
  end
  assign lane_eq[HOLD] = (din == KEY[BYTE_W-1:0]);

  assign match = full && (&lane_eq);

  AST_WIN_SHIFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift && clear)) else $error("window shift and clear together"); // R10
endmodule

// File: rtl/cfg_align_packer.sv
module cfg_align_packer
  import cfg_align_pkg::*;
#(
  parameter byte_t FILL = FILL_DEFAULT,
  localparam int PW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          flush,
  input  byte_t         din,
  output logic [PW-1:0] pos,
  output logic          last,
  output word_t         full_word,
  output word_t         pad_word
);
  localparam int HOLD = LANES - 1;

  byte_t acc [HOLD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      for (int i = 0; i < HOLD; i++) acc[i] <= '0;
    end else if (flush) begin
      pos <= '0;
    end else if (push) begin
      for (int i = 0; i < HOLD - 1; i++) acc[i] <= acc[i+1];
      acc[HOLD-1] <= din;
      pos <= last ? '0 : pos + 1'b1;
    end
  end

  assign last = (pos == PW'(HOLD));

  for (genvar k = 0; k < HOLD; k++) begin : g_full
    assign full_word[WORD_W-1-BYTE_W*k -: BYTE_W] = acc[k];
  end
  assign full_word[BYTE_W-1:0] = din;

  for (genvar k = 0; k < LANES; k++) begin : g_pad
    logic [PW-1:0] idx;
    assign idx = PW'(HOLD) - pos + PW'(k);
    assign pad_word[WORD_W-1-BYTE_W*k -: BYTE_W] = (PW'(k) < pos) ? acc[idx] : FILL;
  end

  AST_FLUSH_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (pos != '0)) else $error("fill word with nothing collected"); // R4
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pos == '0)) else $error("collected count kept after fill"); // R3
  AST_PUSH_XOR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && flush)) else $error("push during fill"); // R9
endmodule

// File: rtl/cfg_align_outreg.sv
module cfg_align_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data))) else $error("output changed under stall"); // R8
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid || ready)) else $error("output overwritten"); // R9
endmodule

// File: rtl/cfg_word_aligner.sv
module cfg_word_aligner
  import cfg_align_pkg::*;
#(
  parameter word_t SYNC_KEY  = SYNC_DEFAULT,
  parameter word_t END_KEY   = END_DEFAULT,
  parameter byte_t FILL_BYTE = FILL_DEFAULT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  output logic        byte_ready,
  input  logic [7:0]  byte_data,
  output logic        word_valid,
  input  logic        word_ready,
  output logic [31:0] word_data,
  output logic        locked,
  output logic        stream_end
);
  localparam int PW = $clog2(LANES);

  mode_t         mode_q;
  logic          end_q;
  logic          can_load;
  logic          w_shift, w_clear, w_full, w_match;
  byte_t         w_oldest;
  logic          p_push, p_flush, p_last;
  byte_t         p_din;
  logic [PW-1:0] p_pos;
  word_t         p_word, p_pad;
  logic          ld;
  word_t         ld_data;
  logic          set_lock, clr_lock, pulse_end;

  cfg_align_window #(.KEY(SYNC_KEY)) u_window (
    .clk(clk), .rst_n(rst_n), .shift(w_shift), .clear(w_clear), .din(byte_data),
    .full(w_full), .match(w_match), .oldest(w_oldest)
  );

  cfg_align_packer #(.FILL(FILL_BYTE)) u_packer (
    .clk(clk), .rst_n(rst_n), .push(p_push), .flush(p_flush), .din(p_din),
    .pos(p_pos), .last(p_last), .full_word(p_word), .pad_word(p_pad)
  );

  cfg_align_outreg #(.W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(ld), .din(ld_data), .ready(word_ready),
    .valid(word_valid), .data(word_data)
  );

  assign can_load = !word_valid || word_ready;

  always_comb begin
    byte_ready = 1'b0;
    w_shift    = 1'b0;
    w_clear    = 1'b0;
    p_push     = 1'b0;
    p_flush    = 1'b0;
    p_din      = byte_data;
    ld         = 1'b0;
    ld_data    = p_word;
    set_lock   = 1'b0;
    clr_lock   = 1'b0;
    pulse_end  = 1'b0;
    if (mode_q == MODE_SEEK) begin
      if (!w_full) begin
        byte_ready = 1'b1;
        w_shift    = byte_valid;
      end else if (byte_valid && w_match) begin
        if (p_pos != '0) begin
          p_flush = can_load;
          ld      = can_load;
          ld_data = p_pad;
        end else begin
          byte_ready = can_load;
          if (can_load) begin
            ld       = 1'b1;
            ld_data  = SYNC_KEY;
            w_clear  = 1'b1;
            set_lock = 1'b1;
          end
        end
      end else begin
        p_din      = w_oldest;
        byte_ready = p_last ? can_load : 1'b1;
        if (byte_valid && byte_ready) begin
          w_shift = 1'b1;
          p_push  = 1'b1;
          ld      = p_last;
        end
      end
    end else begin
      byte_ready = p_last ? can_load : 1'b1;
      if (byte_valid && byte_ready) begin
        p_push = 1'b1;
        if (p_last) begin
          ld = 1'b1;
          if (p_word == END_KEY) begin
            clr_lock  = 1'b1;
            pulse_end = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SEEK;
      end_q  <= 1'b0;
    end else begin
      end_q <= pulse_end;
      if (set_lock)      mode_q <= MODE_LOCKED;
      else if (clr_lock) mode_q <= MODE_SEEK;
    end
  end

  assign locked     = (mode_q == MODE_LOCKED);
  assign stream_end = end_q;

  AST_LOCK_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (word_valid && word_data == SYNC_KEY)) else $error("lock without keyword word"); // R5
  AST_END_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    stream_end |-> (word_valid && word_data == END_KEY && !locked)) else $error("end pulse misplaced"); // R7
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stream_end |=> !stream_end) else $error("end pulse too long"); // R7
  AST_NO_FILL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !p_flush) else $error("fill while locked"); // R6
endmodule

// File: tb/cfg_word_aligner_test.sv
module cfg_word_aligner_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SYNC = 32'hAA995566;
  localparam logic [31:0] DSYN = 32'h0000000D;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_valid;
  logic        byte_ready;
  logic [7:0]  byte_data;
  logic        word_valid;
  logic        word_ready;
  logic [31:0] word_data;
  logic        locked;
  logic        stream_end;

  cfg_word_aligner uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .locked(locked), .stream_end(stream_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int ends_seen = 0;
  int ends_exp  = 0;
  logic [31:0] exp_w[$];
  bit          exp_lk[$];
  string       exp_req[$];
  logic [7:0]  pre[$];
  logic [7:0]  pay[$];
  bit bp_en  = 1'b0;
  bit gap_en = 1'b0;
  logic [7:0] lfsr = 8'h5B;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    word_ready = bp_en ? (lfsr[1] | lfsr[4]) : 1'b1;
  end

  // Monitor: pops the scoreboard on every accepted word
  bit          prev_stall = 1'b0;
  logic [31:0] prev_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(word_valid && word_data == prev_data, "R8", "held word", word_data, prev_data);
      if (stream_end) begin
        ends_seen++;
        check(word_valid && word_data == DSYN && !locked, "R7", "end pulse word", word_data, DSYN);
      end
      if (word_valid && word_ready) begin
        if (exp_w.size() == 0) begin
          check(1'b0, "R9", "unexpected word", word_data, 32'h0);
        end else begin
          logic [31:0] e;
          bit          l;
          string       r;
          e = exp_w.pop_front();
          l = exp_lk.pop_front();
          r = exp_req.pop_front();
          check(word_data == e, r, "word", word_data, e);
          check(locked == l, "R5", "locked flag", {31'b0, locked}, {31'b0, l});
        end
      end
      prev_stall = word_valid && !word_ready;
      prev_data  = word_data;
    end
  end

  task automatic drive_byte(input logic [7:0] b);
    @(negedge clk);
    if (gap_en && lfsr[2]) begin
      byte_valid = 1'b0;
      @(negedge clk);
    end
    byte_valid = 1'b1;
    byte_data  = b;
    #1;
    while (!byte_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    byte_valid = 1'b0;
  endtask

  task automatic add_pre(input logic [31:0] w);
    for (int j = 0; j < 4; j++) pre.push_back(w[31-8*j -: 8]);
  endtask

  task automatic add_pay(input logic [31:0] w);
    for (int j = 0; j < 4; j++) pay.push_back(w[31-8*j -: 8]);
  endtask

  // Driver: builds expected words from the requirements, then drives bytes
  task automatic send_txn(input string pre_req, input string pay_req);
    for (int i = 0; i < pre.size(); i += 4) begin
      logic [31:0] w;
      w = 32'hFFFF_FFFF;
      for (int j = 0; j < 4; j++)
        if (i + j < pre.size()) w[31-8*j -: 8] = pre[i+j];
      exp_w.push_back(w); exp_lk.push_back(1'b0); exp_req.push_back(pre_req);
    end
    exp_w.push_back(SYNC); exp_lk.push_back(1'b1); exp_req.push_back(pre_req);
    for (int i = 0; i < pay.size(); i += 4) begin
      exp_w.push_back({pay[i], pay[i+1], pay[i+2], pay[i+3]});
      exp_lk.push_back(1'b1); exp_req.push_back(pay_req);
    end
    exp_w.push_back(DSYN); exp_lk.push_back(1'b0); exp_req.push_back("R7");
    ends_exp++;
    foreach (pre[i]) drive_byte(pre[i]);
    for (int j = 0; j < 4; j++) drive_byte(SYNC[31-8*j -: 8]);
    foreach (pay[i]) drive_byte(pay[i]);
    for (int j = 0; j < 4; j++) drive_byte(DSYN[31-8*j -: 8]);
    while (exp_w.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!locked, "R7", "search resumed", {31'b0, locked}, 32'h0);
    pre.delete();
    pay.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", exp_w.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    byte_valid = 1'b0;
    byte_data = 8'h00;
    word_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(!word_valid, "R1", "valid in reset", {31'b0, word_valid}, 32'h0);
    check(!locked && !stream_end, "R1", "flags in reset", {30'b0, locked, stream_end}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(byte_ready && !word_valid, "R1", "ready after reset", {30'b0, byte_ready, word_valid}, 32'h2);

    // R11: detection pair after one lead byte, keyword at offset 1 -> 3 fill bytes
    pre.push_back(8'h5A);
    add_pre(32'hFFFF_FFFF); add_pre(32'h0000_00BB); add_pre(32'h1122_0044); add_pre(32'hFFFF_FFFF);
    add_pay(32'h0123_4567); add_pay(32'h89AB_CDEF); add_pay(32'h3000_8001); add_pay(32'h0000_0000);
    send_txn("R11", "R2");

    // R4: keyword already on a word boundary
    add_pre(32'hFFFF_FFFF); add_pre(32'h0000_00BB);
    add_pay(32'hDEAD_BEEF);
    send_txn("R4", "R2");

    // R3: one collected byte
    pre.push_back(8'h12);
    add_pay(32'h1111_2222); add_pay(32'h3333_4444);
    send_txn("R3", "R2");

    // R3: three collected bytes
    pre.push_back(8'hA1); pre.push_back(8'hB2); pre.push_back(8'hC3);
    add_pay(32'h5566_7788);
    send_txn("R3", "R2");

    // R10: partial keyword prefixes in the preamble, then offset 2
    pre.push_back(8'h01); pre.push_back(8'hAA); pre.push_back(8'h99); pre.push_back(8'h55);
    pre.push_back(8'h00); pre.push_back(8'hAA); pre.push_back(8'h99); pre.push_back(8'h02);
    pre.push_back(8'hAA); pre.push_back(8'hAA);
    add_pay(32'hCAFE_F00D);
    send_txn("R10", "R2");

    // R6: keyword copies inside the locked payload
    pre.push_back(8'h77); pre.push_back(8'h88);
    add_pay(32'hAA99_5566); add_pay(32'h00AA_9955); add_pay(32'h6600_0001); add_pay(32'h1234_5678);
    send_txn("R3", "R6");

    // R4: keyword as the first bytes after an end
    add_pay(32'h0F0E_0D0C);
    send_txn("R4", "R6");

    // R9 / R8: input gaps and output back-pressure
    bp_en = 1'b1;
    gap_en = 1'b1;
    pre.push_back(8'h31); pre.push_back(8'h32);
    add_pre(32'h0000_00BB); add_pre(32'h1122_0044);
    for (int i = 0; i < 6; i++) add_pay(32'h1000_0000 + 32'(i * 32'h0101_0101));
    send_txn("R9", "R8");
    pre.push_back(8'h41);
    add_pay(32'h7654_3210); add_pay(32'hFEDC_BA98);
    send_txn("R3", "R9");
    bp_en = 1'b0;
    gap_en = 1'b0;
    repeat (4) @(negedge clk);

    check(ends_seen == ends_exp, "R7", "end pulse count", 32'(ends_seen), 32'(ends_exp));
    check(exp_w.size() == 0 && !word_valid, "R9", "all words drained",
          32'(exp_w.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule